// File: doc/BRIEF.md
# Nested Interrupt Level Controller

This block sits between a group of up to eight peripheral interrupt sources and a processor core. It decides whether a pending request may interrupt the code that is running now. Software gives every source a 2-bit urgency level. A numerically smaller level is more urgent. The running context is described by a current level and a global enable flag. A request may preempt the running context only when the enable flag is set and the request's level is strictly below the current level.

When a request is taken, the block does four things. It pulses an accept strobe for one cycle, together with the index of the source. It lowers the current level to the level of that source. It saves the previous level and enable flag in a small hardware save stack. A return strobe takes the top entry off the stack and puts that level and enable flag back.

Software can write the current level and enable flag directly through a context write port, for example to mask requests inside a handler. Saving the program counter and fetching the vector are left to the core.

Top module: `irq_nest_unit`

## Requirements
- R1: After reset the current level is 3 and the enable flag is 0. Every source level reads as 3. The accept strobe and the overflow flag are low.
- R2: Take a cycle in which the enable flag is 1 and a source request bit is 1 with a programmed level (values 0 to 3) numerically below the current level. Then, one clock later, acceptPulse is 1, acceptIdx holds the source number, and the current level equals that source's level.
- R3: A source programmed to level 3 is never accepted, whatever the context.
- R4: While the enable flag is 0, no request is accepted.
- R5: While the current level is 0, no request is accepted.
- R6: Among the requests that qualify, the one with the smallest level wins. When levels are equal, the lowest source index wins. At most one request is accepted per cycle.
- R7: A request that stays pending after it has been accepted is not accepted again while the current level blocks it. The accept strobe therefore lasts a single cycle.
- R8: A return strobe with a non-empty stack restores the level and enable flag that were saved by the most recent accept, in last-in, first-out order across nested accepts.
- R9: The save stack holds 4 entries. If a request qualifies while 4 entries are held, it is not accepted. In that case overflow is 1 in the following cycle and the context does not change. Overflow is 0 in every other cycle.
- R10: A return strobe on an empty stack is ignored, and the current level and enable flag are kept.
- R11: In a cycle with a return strobe or a context write, no request is accepted. If a return and a context write occur in the same cycle with a non-empty stack, the return wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lvlWrEn | input | 1 | Write strobe for one source level |
| lvlWrIdx | input | 3 | Source whose level is written |
| lvlWrData | input | 2 | New level for that source |
| ctxWrEn | input | 1 | Write strobe for the running context |
| ctxWrEnable | input | 1 | New global enable flag |
| ctxWrLevel | input | 2 | New current level |
| reqVec | input | 8 | Pending request bit for each source |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| acceptPulse | output | 1 | One-cycle accept strobe |
| acceptIdx | output | 3 | Index of the accepted source |
| overflow | output | 1 | A qualifying request was refused because the stack was full |
| curLevel | output | 2 | Current context level |
| curEnable | output | 1 | Current global enable flag |

## Verification
The checker tests some rules in every cycle:
- An accept always lowers the current level, and only happens while the enable flag was set.
- A disabled context or a level-0 context never leads to an accept.
- A return or context write suppresses acceptance in that cycle.
- Overflow and accept are never high together.
- A return on an empty stack leaves the context unchanged.

Other behaviour can only be shown by the bench's scenarios:
- which source wins, and its index, across all request patterns and level mixes;
- the exact values restored in last-in, first-out order;
- the reset value of every source level;
- overflow appearing at exactly the fifth nesting.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int LVL_W = 2;

  typedef logic [LVL_W-1:0] level_t;

  // saved / running context
  typedef struct packed {
    logic   enable;
    level_t level;
  } ctx_t;

  // control -> datapath strobes
  typedef struct packed {
    logic   push;
    logic   pop;
    logic   load;
    level_t pushLevel;
  } ctl_strobe_t;
endpackage

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lvlWrEn,
  input  logic [$clog2(NUM_SRC)-1:0] lvlWrIdx,
  input  level_t                     lvlWrData,
  input  logic                       ctxWrEnable,
  input  level_t                     ctxWrLevel,
  input  ctl_strobe_t                strobe,
  output level_t [NUM_SRC-1:0]       srcLevel,
  output ctx_t                       curCtx,
  output logic                       stackFull,
  output logic                       stackEmpty
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam level_t LVL_MAX = '1;

  // per-source level registers
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rstN)
        srcLevel[g] <= LVL_MAX;
      else if (lvlWrEn && lvlWrIdx == IDX_W'(g))
        srcLevel[g] <= lvlWrData;
    end
  end

  // save stack
  ctx_t             stackMem [STACK_DEPTH];
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  assign wrPtr      = PTR_W'(count);
  assign rdPtr      = PTR_W'(count - CNT_W'(1));
  assign stackFull  = (count == CNT_W'(STACK_DEPTH));
  assign stackEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.pop && !strobe.load)
      stackMem[wrPtr] <= curCtx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCtx <= '{enable: 1'b0, level: LVL_MAX};
      count  <= '0;
    end else if (strobe.pop) begin
      curCtx <= stackMem[rdPtr];
      count  <= count - CNT_W'(1);
    end else if (strobe.load) begin
      curCtx <= '{enable: ctxWrEnable, level: ctxWrLevel};
    end else if (strobe.push) begin
      curCtx.level <= strobe.pushLevel;
      count        <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         reqVec,
  input  logic                       retStrobe,
  input  logic                       ctxWrEn,
  input  level_t [NUM_SRC-1:0]       srcLevel,
  input  ctx_t                       curCtx,
  input  logic                       stackFull,
  input  logic                       stackEmpty,
  output ctl_strobe_t                strobe,
  output logic                       acceptPulse,
  output logic [$clog2(NUM_SRC)-1:0] acceptIdx,
  output logic                       overflow
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic             found;
  logic [IDX_W-1:0] winIdx;
  level_t           winLvl;
  logic             qualify;
  logic             blocked;

  // scan from high index down; <= lets lower indices take ties
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    winLvl = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i] && (srcLevel[i] < curCtx.level) &&
          (!found || srcLevel[i] <= winLvl)) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
        winLvl = srcLevel[i];
      end
    end
  end

  assign qualify = found && curCtx.enable;
  assign blocked = retStrobe || ctxWrEn;

  always_comb begin
    strobe.pop       = retStrobe && !stackEmpty;
    strobe.load      = ctxWrEn && !strobe.pop;
    strobe.push      = qualify && !blocked && !stackFull;
    strobe.pushLevel = winLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptPulse <= 1'b0;
      acceptIdx   <= '0;
      overflow    <= 1'b0;
    end else begin
      acceptPulse <= strobe.push;
      overflow    <= qualify && !blocked && stackFull;
      if (strobe.push)
        acceptIdx <= winIdx;
    end
  end
endmodule

// File: rtl/irq_nest_unit.sv
module irq_nest_unit
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lvlWrEn,
  input  logic [$clog2(NUM_SRC)-1:0] lvlWrIdx,
  input  logic [1:0]                 lvlWrData,
  input  logic                       ctxWrEn,
  input  logic                       ctxWrEnable,
  input  logic [1:0]                 ctxWrLevel,
  input  logic [NUM_SRC-1:0]         reqVec,
  input  logic                       retStrobe,
  output logic                       acceptPulse,
  output logic [$clog2(NUM_SRC)-1:0] acceptIdx,
  output logic                       overflow,
  output logic [1:0]                 curLevel,
  output logic                       curEnable
);
  ctl_strobe_t          strobe;
  level_t [NUM_SRC-1:0] srcLevel;
  ctx_t                 curCtx;
  logic                 stackFull;
  logic                 stackEmpty;

  irq_nest_dp #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN),
    .lvlWrEn(lvlWrEn), .lvlWrIdx(lvlWrIdx), .lvlWrData(lvlWrData),
    .ctxWrEnable(ctxWrEnable), .ctxWrLevel(ctxWrLevel),
    .strobe(strobe), .srcLevel(srcLevel), .curCtx(curCtx),
    .stackFull(stackFull), .stackEmpty(stackEmpty)
  );

  irq_nest_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqVec(reqVec), .retStrobe(retStrobe), .ctxWrEn(ctxWrEn),
    .srcLevel(srcLevel), .curCtx(curCtx),
    .stackFull(stackFull), .stackEmpty(stackEmpty),
    .strobe(strobe), .acceptPulse(acceptPulse), .acceptIdx(acceptIdx),
    .overflow(overflow)
  );

  assign curLevel  = curCtx.level;
  assign curEnable = curCtx.enable;
endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker (
  input logic       clk,
  input logic       rstN,
  input logic       acceptPulse,
  input logic       overflow,
  input logic [1:0] curLevel,
  input logic       curEnable,
  input logic       retStrobe,
  input logic       ctxWrEn,
  input logic       stackEmpty
);
  assert_accept_lowers_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> ($past(curEnable) && curLevel < $past(curLevel)));

  assert_never_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> curLevel != 2'd3);

  assert_disabled_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    !curEnable |=> !acceptPulse);

  assert_zero_level_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == 2'd0) |=> !acceptPulse);

  assert_no_overflow_with_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && overflow));

  assert_empty_return_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && stackEmpty && !ctxWrEn) |=> ($stable(curLevel) && $stable(curEnable)));

  assert_control_suppresses_R11: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe || ctxWrEn) |=> (!acceptPulse && !overflow));
endmodule

bind irq_nest_unit irq_nest_checker u_chk (
  .clk(clk), .rstN(rstN), .acceptPulse(acceptPulse), .overflow(overflow),
  .curLevel(curLevel), .curEnable(curEnable), .retStrobe(retStrobe),
  .ctxWrEn(ctxWrEn), .stackEmpty(stackEmpty)
);

// File: tb/test_irq_nest_unit.sv
`timescale 1ns/1ps
module test_irq_nest_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lvlWrEn = 1'b0;
  logic [2:0] lvlWrIdx = '0;
  logic [1:0] lvlWrData = '0;
  logic       ctxWrEn = 1'b0;
  logic       ctxWrEnable = 1'b0;
  logic [1:0] ctxWrLevel = '0;
  logic [7:0] reqVec = '0;
  logic       retStrobe = 1'b0;
  logic       acceptPulse;
  logic [2:0] acceptIdx;
  logic       overflow;
  logic [1:0] curLevel;
  logic       curEnable;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int lvlModel [8];

  always #10 clk = ~clk;

  irq_nest_unit i_irq_nest_unit (
    .clk(clk), .rstN(rstN), .lvlWrEn(lvlWrEn), .lvlWrIdx(lvlWrIdx),
    .lvlWrData(lvlWrData), .ctxWrEn(ctxWrEn), .ctxWrEnable(ctxWrEnable),
    .ctxWrLevel(ctxWrLevel), .reqVec(reqVec), .retStrobe(retStrobe),
    .acceptPulse(acceptPulse), .acceptIdx(acceptIdx), .overflow(overflow),
    .curLevel(curLevel), .curEnable(curEnable)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setLevel(input int idx, input int lvl);
    lvlWrEn = 1'b1; lvlWrIdx = 3'(idx); lvlWrData = 2'(lvl);
    tick();
    lvlWrEn = 1'b0;
    lvlModel[idx] = lvl;
  endtask

  task automatic setCtx(input int en, input int lvl);
    ctxWrEn = 1'b1; ctxWrEnable = 1'(en); ctxWrLevel = 2'(lvl);
    tick();
    ctxWrEn = 1'b0;
  endtask

  task automatic doRet();
    retStrobe = 1'b1;
    tick();
    retStrobe = 1'b0;
  endtask

  // expected winner: most urgent level, lowest index on ties; -1 if none
  function automatic int model(input logic [7:0] req, input int il, input int en);
    int best = -1;
    if (en == 0) return -1;
    for (int i = 0; i < 8; i++)
      if (req[i] && lvlModel[i] < il && (best < 0 || lvlModel[i] < lvlModel[best]))
        best = i;
    return best;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) lvlModel[i] = 3;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 level", curLevel, 3);
    chk("R1 enable", curEnable, 0);
    chk("R1 pulse", acceptPulse, 0);
    chk("R1 overflow", overflow, 0);
    setCtx(1, 3);
    reqVec = 8'hFF;
    tick();
    chk("R1 all levels reset to 3", acceptPulse, 0);
    reqVec = '0;

    // single-source sweep: R2 R3 R4 R5 R7 R8
    for (int s = 0; s < 8; s++)
      for (int lvl = 0; lvl < 4; lvl++)
        for (int il = 0; il < 4; il++)
          for (int en = 0; en < 2; en++) begin
            string tag;
            bit exp;
            setLevel(s, lvl);
            setCtx(en, il);
            reqVec = 8'(1 << s);
            tick();
            exp = (en == 1) && (lvl < il);
            if (en == 0) tag = "R4";
            else if (il == 0) tag = "R5";
            else if (lvl == 3) tag = "R3";
            else tag = "R2";
            chk(tag, acceptPulse, int'(exp));
            chk({tag, " level"}, curLevel, exp ? lvl : il);
            if (exp) chk("R2 idx", acceptIdx, s);
            tick();
            chk("R7 no re-accept", acceptPulse, 0);
            reqVec = '0;
            if (exp) begin
              doRet();
              chk("R8 restore level", curLevel, il);
              chk("R8 restore enable", curEnable, en);
            end
          end

    // priority sweep R6
    for (int cfg = 0; cfg < 3; cfg++) begin
      for (int i = 0; i < 8; i++) setLevel(i, (i * (cfg + 1) + cfg * 3) % 4);
      setCtx(1, 3);
      for (int p = 1; p < 256; p++) begin
        int w;
        reqVec = 8'(p);
        w = model(8'(p), 3, 1);
        tick();
        chk("R6 pulse", acceptPulse, int'(w >= 0));
        if (w >= 0) begin
          chk("R6 idx", acceptIdx, w);
          chk("R6 level", curLevel, lvlModel[w]);
        end
        reqVec = '0;
        if (w >= 0) doRet();
      end
    end

    // nesting, overflow, LIFO restore: R8 R9 R10
    setLevel(0, 0);
    setLevel(1, 1);
    setCtx(1, 3); reqVec = 8'h01; tick(); chk("R9 push1", acceptPulse, 1); reqVec = '0;
    setCtx(1, 2); reqVec = 8'h01; tick(); chk("R9 push2", acceptPulse, 1); reqVec = '0;
    setCtx(1, 1); reqVec = 8'h01; tick(); chk("R9 push3", acceptPulse, 1); reqVec = '0;
    setCtx(1, 3); reqVec = 8'h02; tick(); chk("R9 push4", acceptPulse, 1);
    chk("R9 push4 level", curLevel, 1); reqVec = '0;
    setCtx(1, 2);
    reqVec = 8'h01;
    tick();
    chk("R9 fifth refused", acceptPulse, 0);
    chk("R9 overflow", overflow, 1);
    chk("R9 level kept", curLevel, 2);
    tick();
    chk("R9 overflow held", overflow, 1);
    reqVec = '0;
    tick();
    chk("R9 overflow clear", overflow, 0);
    setCtx(0, 2);
    doRet(); chk("R8 pop4 level", curLevel, 3); chk("R8 pop4 enable", curEnable, 1);
    doRet(); chk("R8 pop3 level", curLevel, 1);
    doRet(); chk("R8 pop2 level", curLevel, 2);
    doRet(); chk("R8 pop1 level", curLevel, 3);
    setCtx(0, 1);
    doRet();
    chk("R10 empty ret level", curLevel, 1);
    chk("R10 empty ret enable", curEnable, 0);

    // R11 suppression and precedence
    setLevel(2, 1);
    setCtx(1, 3);
    reqVec = 8'h04;
    ctxWrEn = 1'b1; ctxWrEnable = 1'b1; ctxWrLevel = 2'd3;
    tick();
    ctxWrEn = 1'b0;
    chk("R11 ctx write suppresses", acceptPulse, 0);
    tick();
    chk("R11 accept after", acceptPulse, 1);
    chk("R11 idx", acceptIdx, 2);
    reqVec = '0;
    retStrobe = 1'b1; ctxWrEn = 1'b1; ctxWrEnable = 1'b1; ctxWrLevel = 2'd0;
    tick();
    retStrobe = 1'b0; ctxWrEn = 1'b0;
    chk("R11 return wins level", curLevel, 3);
    reqVec = 8'h04;
    retStrobe = 1'b1;
    tick();
    retStrobe = 1'b0;
    chk("R11 return suppresses", acceptPulse, 0);
    reqVec = '0;
    tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule